// File: doc/BRIEF.md
# Addressed Read-Only Serial Diagnostic Slave

This block is the target side of a four-wire serial link. A host selects it with an active-low chip select and clocks out fixed sixteen-bit frames. The first byte the host sends is an instruction. It holds a two-bit chip address, so that up to four devices can share one select line. It also holds a five-bit command and an even-parity bit. The second byte the host sends carries nothing and is discarded.

During the same frame, the slave returns two bytes. The first is a check pattern whose lowest bit reports whether the previous addressed frame was faulty. The second is the byte the command asked for: a fixed identifier, a version byte, or a snapshot of an 8-bit diagnostic register that sits outside this block.

The serial pins are asynchronous to the block clock. They are synchronised and edge-detected inside the block. The output data line comes with a separate drive-enable, so that the pad can float while another device owns the bus. When a diagnostic read completes without error, the block sends a one-cycle clear request to the diagnostic register.

Top module: `spi_diag_slave`

## Requirements
- R1: While `cs_n` is low, `sdi` is captured on each falling `sck` edge, most significant bit first. `sdo` changes only after a rising `sck` edge. The k-th rising edge presents word bit 16-k, where word bits 15..8 are the check byte and bits 7..0 are the data byte.
- R2: `sdo_oe` is low after reset, whenever `cs_n` is high, and for the first two bit slots of every frame. From slot 3 through slot 16 it is high only when both address bits (instruction bits 7:6) were received as 00. After slot 16 it is low again.
- R3: When the address bits are not 00, `sdo_oe` stays low for the whole frame, the error flag is left unchanged, and no clear request is issued.
- R4: Check byte bits 5 down to 1 read 1,0,1,0,1. Bit 0 is the error flag as it stood at the start of the frame. Bits 7 and 6 fall in the undriven slots.
- R5: Instruction bits 5:1 select the data byte: 00000 gives 0xA2, 00001 gives {4'b0000, `MASK_REV`}, and 00100 gives `diag_i` as sampled when the eighth instruction bit is captured.
- R6: An instruction byte with an odd number of ones is treated as an unused command.
- R7: An unused command (any other code, or a parity error) returns data byte 0xFF and sets the error flag for the next frame.
- R8: An addressed frame with a falling-edge count other than exactly 16 sets the error flag.
- R9: An addressed frame in which `sck` is high when `cs_n` falls sets the error flag.
- R10: The error flag resets to 0. It is cleared only at the end of an addressed frame that had at least 8 rising edges, that is, once the flag has been sent. A new error at the end of that same frame sets it again.
- R11: `diag_clr` pulses high for exactly one clock after `cs_n` rises, and only when the frame had address 00, command 00100, valid parity, 16 falling edges and no clock-high start. It stays low in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sck | input | 1 | Serial clock from the host, idle low |
| sdi | input | 1 | Serial data from the host |
| diag_i | input | 8 | Current contents of the diagnostic register |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Drive enable for the `sdo` pad |
| diag_clr | output | 1 | One-cycle clear request to the diagnostic register |

## Verification
Every pin change passes through two synchroniser stages and one edge register before it reaches `sdo` and `sdo_oe`. Those outputs therefore settle on the third clock after an `sck` rise. The bench holds each serial clock phase for eight block clocks and samples at the end of the high phase. The `diag_clr` pulse and the error-flag update follow a rise of `cs_n` by the same three clocks. The bench counts clear pulses over a window that spans the frame end. The error flag is observed at the ports only through the check byte of the next addressed frame. The reference model carries the flag from frame to frame and predicts every driven bit and every undriven slot.

// File: rtl/spi_diag_pkg.sv
package spi_diag_pkg;

  localparam int BYTE_W = 8;

  localparam logic [1:0] OWN_ADDR  = 2'b00;
  localparam logic [4:0] CMD_IDENT = 5'b00000;
  localparam logic [4:0] CMD_VER   = 5'b00001;
  localparam logic [4:0] CMD_DIAG  = 5'b00100;

  localparam logic [BYTE_W-1:0] IDENT_BYTE  = 8'hA2;
  localparam logic [BYTE_W-1:0] UNUSED_BYTE = 8'hFF;
  // upper seven bits of the check byte; bits 7:6 fall in undriven slots
  localparam logic [6:0] CHECK_PATTERN = 7'b1110101;

  typedef enum logic [1:0] {
    SEL_IDENT,
    SEL_VER,
    SEL_DIAG,
    SEL_NONE
  } data_sel_e;

  function automatic data_sel_e decode_instr(input logic [BYTE_W-1:0] ins);
    data_sel_e sel;
    if (^ins) begin
      sel = SEL_NONE;
    end else begin
      case (ins[5:1])
        CMD_IDENT: sel = SEL_IDENT;
        CMD_VER:   sel = SEL_VER;
        CMD_DIAG:  sel = SEL_DIAG;
        default:   sel = SEL_NONE;
      endcase
    end
    return sel;
  endfunction

endpackage

// File: rtl/spi_diag_sync.sv
module spi_diag_sync #(
  parameter int             W      = 3,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   INIT   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= INIT;
        else     stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= INIT;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_diag_rx.sv
module spi_diag_rx
  import spi_diag_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              cs_p,
  input  logic              sck_s,
  input  logic              sck_p,
  input  logic              sdi_s,
  output logic [CNT_W-1:0]  fall_cnt,
  output logic [CNT_W-1:0]  rise_cnt,
  output logic [BYTE_W-1:0] instr,
  output logic              addr_ok,
  output logic              sck_bad
);

  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(1);
  localparam logic [CNT_W-1:0] INSTR_END = CNT_W'(BYTE_W);

  logic cs_fall, active, sck_fall, sck_rise, shift_en;

  assign cs_fall  = cs_p & ~cs_s;
  assign active   = ~cs_s;
  assign sck_fall = active & sck_p & ~sck_s;
  assign sck_rise = active & ~sck_p & sck_s;
  // after a mismatching address nothing more is taken in
  assign shift_en = (fall_cnt < INSTR_END) &&
                    ((fall_cnt <= ADDR_LAST) || addr_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      fall_cnt <= '0;
      rise_cnt <= '0;
      instr    <= '0;
      addr_ok  <= 1'b0;
      sck_bad  <= 1'b0;
    end else if (cs_fall) begin
      fall_cnt <= '0;
      rise_cnt <= '0;
      instr    <= '0;
      addr_ok  <= 1'b0;
      sck_bad  <= sck_s;
    end else if (active) begin
      if (sck_fall) begin
        if (fall_cnt != CNT_MAX) fall_cnt <= fall_cnt + 1'b1;
        if (shift_en) instr <= {instr[BYTE_W-2:0], sdi_s};
        if (fall_cnt == ADDR_LAST) addr_ok <= ({instr[0], sdi_s} == OWN_ADDR);
      end
      if (sck_rise && rise_cnt != CNT_MAX) rise_cnt <= rise_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/spi_diag_tx.sv
module spi_diag_tx
  import spi_diag_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int CNT_W      = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              rise_ev,
  input  logic [CNT_W-1:0]  rise_cnt,
  input  logic              addr_ok,
  input  logic              trans_f,
  input  logic [BYTE_W-1:0] data_byte,
  output logic              sdo,
  output logic              sdo_oe
);

  localparam logic [CNT_W-1:0] FIRST_DRIVEN = CNT_W'(3);
  localparam logic [CNT_W-1:0] LAST_SLOT    = CNT_W'(FRAME_BITS);

  logic [CNT_W-1:0]      slot;
  logic [FRAME_BITS-1:0] word, word_sh;
  logic                  slot_ok;

  assign slot    = rise_cnt + 1'b1;
  assign word    = {CHECK_PATTERN, trans_f, data_byte};
  assign word_sh = word << (slot - 1'b1);
  assign slot_ok = (slot >= FIRST_DRIVEN) && (slot <= LAST_SLOT);

  always_ff @(posedge clk) begin
    if (rst || cs_s) begin
      sdo    <= 1'b1;
      sdo_oe <= 1'b0;
    end else if (rise_ev) begin
      if (slot_ok && addr_ok) begin
        sdo    <= word_sh[FRAME_BITS-1];
        sdo_oe <= 1'b1;
      end else begin
        sdo    <= 1'b1;
        sdo_oe <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/spi_diag_slave.sv
module spi_diag_slave
  import spi_diag_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] MASK_REV    = 4'h2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic [BYTE_W-1:0] diag_i,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              diag_clr
);

  localparam int FRAME_BITS = 2 * BYTE_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 4);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] SENT_CNT  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] PRE_DECOD = CNT_W'(BYTE_W - 1);

  logic [2:0]        pins_s;
  logic              cs_s, sck_s, sdi_s, cs_p, sck_p;
  logic              cs_fall, cs_rise, rise_ev, fall_ev, instr_done;
  logic [CNT_W-1:0]  fall_cnt, rise_cnt;
  logic [BYTE_W-1:0] instr, instr_nxt, data_q, data_nxt;
  logic              addr_ok, sck_bad, trans_f, frame_ok;
  data_sel_e         sel_q, sel_nxt;

  spi_diag_sync #(
    .W(3), .STAGES(SYNC_STAGES), .INIT(3'b100)
  ) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sck, sdi}), .q(pins_s)
  );

  assign {cs_s, sck_s, sdi_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p  <= 1'b1;
      sck_p <= 1'b0;
    end else begin
      cs_p  <= cs_s;
      sck_p <= sck_s;
    end
  end

  assign cs_fall = cs_p & ~cs_s;
  assign cs_rise = ~cs_p & cs_s;
  assign rise_ev = ~cs_s & ~sck_p & sck_s;
  assign fall_ev = ~cs_s & sck_p & ~sck_s;

  spi_diag_rx #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .cs_s(cs_s), .cs_p(cs_p),
    .sck_s(sck_s), .sck_p(sck_p), .sdi_s(sdi_s),
    .fall_cnt(fall_cnt), .rise_cnt(rise_cnt), .instr(instr),
    .addr_ok(addr_ok), .sck_bad(sck_bad)
  );

  // command decode happens as the eighth instruction bit lands
  assign instr_nxt  = {instr[BYTE_W-2:0], sdi_s};
  assign instr_done = fall_ev & ~cs_fall & (fall_cnt == PRE_DECOD);
  assign sel_nxt    = decode_instr(instr_nxt);

  always_comb begin
    case (sel_nxt)
      SEL_IDENT: data_nxt = IDENT_BYTE;
      SEL_VER:   data_nxt = {4'b0000, MASK_REV};
      SEL_DIAG:  data_nxt = diag_i;
      default:   data_nxt = UNUSED_BYTE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || cs_fall) begin
      sel_q  <= SEL_NONE;
      data_q <= UNUSED_BYTE;
    end else if (instr_done) begin
      sel_q  <= sel_nxt;
      data_q <= data_nxt;
    end
  end

  assign frame_ok = (fall_cnt == FULL_CNT) && !sck_bad && (sel_q != SEL_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      trans_f  <= 1'b0;
      diag_clr <= 1'b0;
    end else begin
      diag_clr <= 1'b0;
      if (cs_rise && addr_ok) begin
        trans_f  <= !frame_ok || (trans_f && (rise_cnt < SENT_CNT));
        diag_clr <= frame_ok && (sel_q == SEL_DIAG);
      end
    end
  end

  spi_diag_tx #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst(rst), .cs_s(cs_s), .rise_ev(rise_ev),
    .rise_cnt(rise_cnt), .addr_ok(addr_ok), .trans_f(trans_f),
    .data_byte(data_q), .sdo(sdo), .sdo_oe(sdo_oe)
  );

endmodule

// File: rtl/spi_diag_slave_chk.sv
module spi_diag_slave_chk (
  input logic clk,
  input logic rst,
  input logic cs_s,
  input logic cs_p,
  input logic rise_ev,
  input logic addr_ok,
  input logic trans_f,
  input logic sdo,
  input logic sdo_oe,
  input logic diag_clr
);

  AST_OE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> !$past(cs_s)) else $error("sdo_oe while deselected"); // R2

  AST_OE_NEEDS_ADDR: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_oe) |-> ($past(rise_ev) && addr_ok)) else $error("drive without edge or address"); // R2

  AST_SDO_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    (sdo_oe && $past(sdo_oe) && !$past(rise_ev)) |-> $stable(sdo)) else $error("sdo moved off a rising edge"); // R1

  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    diag_clr |=> !diag_clr) else $error("clear longer than one cycle"); // R11

  AST_CLR_AT_END: assert property (@(posedge clk) disable iff (rst)
    diag_clr |-> ($past(cs_s) && !$past(cs_p) && $past(addr_ok))) else $error("clear outside frame end"); // R11

  AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (rst)
    !$past(cs_s && !cs_p) |-> $stable(trans_f)) else $error("error flag changed mid frame"); // R10

endmodule

bind spi_diag_slave spi_diag_slave_chk chk_i (
  .clk(clk), .rst(rst), .cs_s(cs_s), .cs_p(cs_p), .rise_ev(rise_ev),
  .addr_ok(addr_ok), .trans_f(trans_f), .sdo(sdo), .sdo_oe(sdo_oe),
  .diag_clr(diag_clr)
);

// File: tb/spi_diag_slave_tb_top.sv
module spi_diag_slave_tb_top;

  localparam int         HALF     = 8;
  localparam logic [3:0] MASK_REV = 4'h2;

  logic       clk = 1'b0;
  logic       rst;
  logic       cs_n, sck, sdi;
  logic [7:0] diag_i;
  logic       sdo, sdo_oe, diag_clr;

  int  n_chk   = 0;
  int  n_fail  = 0;
  int  clr_cnt = 0;
  bit  m_tf    = 1'b0;
  bit  done    = 1'b0;

  always #10 clk = ~clk;

  spi_diag_slave #(.SYNC_STAGES(2), .MASK_REV(MASK_REV)) dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .diag_i(diag_i), .sdo(sdo), .sdo_oe(sdo_oe), .diag_clr(diag_clr)
  );

  always @(posedge clk) if (!rst && diag_clr) clr_cnt <= clr_cnt + 1;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural frame model: predicts each slot, the clear, and the flag
  task automatic run_frame(input logic [7:0] ins, input int nclk, input bit sck_hi,
                           input string what);
    logic [15:0] word;
    logic [7:0]  dat;
    logic [4:0]  cmd;
    bit          match, valid, err, sent, clr_exp;
    int          c0, rises;
    cmd   = ins[5:1];
    match = (nclk >= 2) && (ins[7:6] == 2'b00);
    valid = (nclk >= 8) && (^ins == 1'b0) &&
            (cmd == 5'b00000 || cmd == 5'b00001 || cmd == 5'b00100);
    if (!valid)                dat = 8'hFF;
    else if (cmd == 5'b00000)  dat = 8'hA2;
    else if (cmd == 5'b00001)  dat = {4'h0, MASK_REV};
    else                       dat = diag_i;
    word  = {7'b1110101, m_tf, dat};
    rises = sck_hi ? nclk - 1 : nclk;
    err   = (nclk != 16) || sck_hi || !valid;
    sent  = rises >= 8;
    clr_exp = match && !err && (cmd == 5'b00100);
    c0 = clr_cnt;

    if (sck_hi) begin sck = 1'b1; sdi = ins[7]; end
    wait_clk(HALF);
    cs_n = 1'b0;
    wait_clk(HALF);
    if (sck_hi) begin sck = 1'b0; wait_clk(HALF); end
    for (int p = (sck_hi ? 2 : 1); p <= nclk; p++) begin
      sck = 1'b1;
      sdi = (p <= 8) ? ins[8-p] : p[0];
      wait_clk(HALF);
      if (!sck_hi) begin
        if (p <= 2 || p > 16)
          chk(sdo_oe == 1'b0, {what, " R2 undriven slot"}, {15'd0, sdo_oe}, 16'd0);
        else if (!match)
          chk(sdo_oe == 1'b0, {what, " R3 foreign frame"}, {15'd0, sdo_oe}, 16'd0);
        else begin
          chk(sdo_oe == 1'b1, {what, " R2 driven slot"}, {15'd0, sdo_oe}, 16'd1);
          chk(sdo == word[16-p], {what, (p <= 8) ? " R4 check bit" : " R1 R5 data bit"},
              {11'd0, 5'(p), sdo}, {11'd0, 5'(p), word[16-p]});
        end
      end
      sck = 1'b0;
      wait_clk(HALF);
    end
    cs_n = 1'b1;
    wait_clk(HALF);
    chk(sdo_oe == 1'b0, {what, " R2 deselected"}, {15'd0, sdo_oe}, 16'd0);
    chk((clr_cnt - c0) == (clr_exp ? 1 : 0), {what, " R11 clear count"},
        16'(clr_cnt - c0), clr_exp ? 16'd1 : 16'd0);
    if (match) m_tf = err || (m_tf && !sent);
  endtask

  initial begin
    rst = 1'b1; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0; diag_i = 8'h5A;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    chk(sdo_oe == 1'b0, "R2 reset drive", {15'd0, sdo_oe}, 16'd0);
    chk(diag_clr == 1'b0, "R11 reset clear", {15'd0, diag_clr}, 16'd0);

    run_frame(8'h00, 16, 1'b0, "R5 R10 ident after reset");
    run_frame(8'h03, 16, 1'b0, "R5 version");
    run_frame(8'h09, 16, 1'b0, "R5 R11 diag read");
    run_frame(8'h05, 16, 1'b0, "R7 unused code");
    run_frame(8'h00, 16, 1'b0, "R7 R10 flag shown");
    run_frame(8'h00, 16, 1'b0, "R10 flag cleared");
    run_frame(8'h01, 16, 1'b0, "R6 bad parity");
    run_frame(8'h00, 16, 1'b0, "R6 flag shown");
    run_frame(8'h00, 10, 1'b0, "R8 short frame");
    run_frame(8'h49, 16, 1'b0, "R3 address 01");
    run_frame(8'h00, 16, 1'b0, "R3 R10 flag kept");
    run_frame(8'h00, 18, 1'b0, "R8 long frame");
    diag_i = 8'hC3;
    run_frame(8'h09, 16, 1'b1, "R9 clock high at select");
    run_frame(8'h09, 15, 1'b0, "R9 R11 short diag read");
    run_frame(8'h09, 16, 1'b0, "R11 diag read again");
    run_frame(8'h89, 16, 1'b0, "R3 address 10 diag");
    run_frame(8'h00, 16, 1'b0, "R10 final ident");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule